// File: doc/BRIEF.md
# Optical Receive Link Monitor

This block judges whether an optical receive path carries a usable signal. It watches two inputs. The first is the sliced receive bit, which must keep changing. The second is a digital flag that says the received amplitude is above threshold. From these it reports link pass or low light. In low light it withholds data enables from the transmit path, the receive path and the loopback path, and it turns the link LED off. The separate idle-tone generator of the transmitter is not gated by these enables, so the idle tone keeps running in low light.

Recovery from low light has three steps. First the amplitude flag must hold for a programmable qualify time, and transitions must be present. Then a settle window runs; a build option can widen it by a pseudo-random offset. Last, the block waits for a quiet line, with no transmit activity and no receive activity, before it grants the enables. The amplitude must be absent for twice the qualify time before a good link is dropped. A gap between transitions that is longer than the allowed maximum drops the link at once. All times are counted in clock cycles.

In the requirements below, edge 1 is the first rising clock edge that samples the new input value.

Top module: `optlink_mon`

## Requirements
- R1: While reset is asserted and directly after it, tx_data_en, rx_en and loop_en are 0 and link_led_n is 1.
- R2: The amplitude flag qualifies after QUAL_CYCLES consecutive clock edges that sample amp_ok high. With transitions present, with tx_busy and rx_busy low, and with JITTER_EN=0, the enables rise after edge QUAL_CYCLES+SETTLE_MIN+2, counted from the first edge that samples amp_ok high.
- R3: On a passing link, amp_ok low for 2*QUAL_CYCLES consecutive edges drops the enables after edge 2*QUAL_CYCLES+1. A dropout of 2*QUAL_CYCLES-1 edges has no effect.
- R4: Changes of rx_bit that are GAP_CYCLES clock cycles apart keep the link. If rx_bit does not change after its last change, the enables drop after edge GAP_CYCLES+2, counted from the edge that samples that last change.
- R5: In low light, tx_data_en, rx_en and loop_en are all 0 and link_led_n is 1.
- R6: In link pass, all three enables are 1 and link_led_n is 0 in the same cycle, with no stretching.
- R7: With JITTER_EN=1, the settle window is SETTLE_MIN plus a pseudo-random offset from 0 to 2**JIT_W-1, so the rise latency of R2 lies in [QUAL_CYCLES+SETTLE_MIN+2, QUAL_CYCLES+SETTLE_MIN+2**JIT_W+1].
- R8: If the amplitude or the transitions are lost during the settle window, the block returns to low light. When conditions return, the settle window restarts from zero.
- R9: After the settle window, the block waits while tx_busy or rx_busy is high. It enters link pass after the first edge that samples both of them low.
- R10: Once in link pass, tx_busy and rx_busy have no effect on the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_bit | input | 1 | Sliced receive data bit |
| amp_ok | input | 1 | Receive amplitude above threshold |
| tx_busy | input | 1 | Transmit input carries data |
| rx_busy | input | 1 | Receive data in progress |
| tx_data_en | output | 1 | Transmit data enable |
| rx_en | output | 1 | Receive path enable |
| loop_en | output | 1 | Loopback path enable |
| link_led_n | output | 1 | Link LED, active low |

## Verification
The bench builds two copies that share the same inputs. Both use QUAL_CYCLES=4, GAP_CYCLES=8 and SETTLE_MIN=20. In the first copy the jitter is off, so every latency of R2, R3, R4, R8 and R9 can be checked to the exact cycle, and an off-by-one in any timer shows up. The second copy has jitter on with JIT_W=2. It is checked against the four-cycle window of R7. These short values make it possible to test a 2*QUAL_CYCLES-1 dropout, a transition period of exactly GAP_CYCLES, and an abort in the middle of the settle window, all within a few hundred cycles.

// File: rtl/optlink_pkg.sv
package optlink_pkg;
   typedef enum logic [1:0] {
      ST_DARK   = 2'd0,
      ST_SETTLE = 2'd1,
      ST_QUIET  = 2'd2,
      ST_PASS   = 2'd3
   } link_st_e;
endpackage

// File: rtl/optlink_gap_timer.sv
module optlink_gap_timer #(
   parameter int GAP_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_bit,
   output logic trans_ok
);
   localparam int GW = $clog2(GAP_CYCLES + 1);

   logic          rx_q;
   logic [GW-1:0] gap_cnt;
   logic          edge_seen;

   assign edge_seen = rx_bit ^ rx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_q     <= 1'b0;
         gap_cnt  <= '0;
         trans_ok <= 1'b0;
      end else begin
         rx_q <= rx_bit;
         if (edge_seen) begin
            gap_cnt  <= '0;
            trans_ok <= 1'b1;
         end else if (gap_cnt == GW'(GAP_CYCLES - 1)) begin
            trans_ok <= 1'b0;
         end else begin
            gap_cnt <= gap_cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/optlink_amp_qual.sv
module optlink_amp_qual #(
   parameter int QUAL_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic amp_ok,
   output logic amp_q
);
   localparam int DROP_CYCLES = 2 * QUAL_CYCLES;
   localparam int AW          = $clog2(DROP_CYCLES + 1);

   logic [AW-1:0] run_cnt;
   logic [AW-1:0] limit;

   assign limit = amp_q ? AW'(DROP_CYCLES - 1) : AW'(QUAL_CYCLES - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         amp_q   <= 1'b0;
         run_cnt <= '0;
      end else if (amp_ok == amp_q) begin
         run_cnt <= '0;
      end else if (run_cnt == limit) begin
         amp_q   <= amp_ok;
         run_cnt <= '0;
      end else begin
         run_cnt <= run_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/optlink_settle.sv
module optlink_settle #(
   parameter int          SETTLE_MIN = 20,
   parameter bit          JITTER_EN  = 1'b0,
   parameter int          JIT_W      = 2,
   parameter logic [15:0] SEED       = 16'hACE1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic run,
   output logic done
);
   localparam int SPAN = 1 << JIT_W;
   localparam int TW   = $clog2(SETTLE_MIN + SPAN + 1);

   logic [JIT_W-1:0] jit;
   logic [TW-1:0]    target;
   logic [TW-1:0]    cnt;

   generate
      if (JITTER_EN) begin : g_jit
         logic [15:0] lfsr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lfsr <= SEED;
            else        lfsr <= {1'b0, lfsr[15:1]} ^ (lfsr[0] ? 16'hB400 : 16'h0000);
         end
         assign jit = lfsr[JIT_W-1:0];
      end else begin : g_fixed
         assign jit = '0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         target <= TW'(SETTLE_MIN);
      end else if (start) begin
         cnt    <= '0;
         target <= TW'(SETTLE_MIN) + TW'(jit);
      end else if (run && !done) begin
         cnt <= cnt + 1'b1;
      end
   end

   assign done = run && (cnt == TW'(target - TW'(1)));
endmodule

// File: rtl/optlink_mon.sv
module optlink_mon #(
   parameter int          QUAL_CYCLES = 4,
   parameter int          GAP_CYCLES  = 8,
   parameter int          SETTLE_MIN  = 20,
   parameter bit          JITTER_EN   = 1'b0,
   parameter int          JIT_W       = 2,
   parameter logic [15:0] SEED        = 16'hACE1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_bit,
   input  logic amp_ok,
   input  logic tx_busy,
   input  logic rx_busy,
   output logic tx_data_en,
   output logic rx_en,
   output logic loop_en,
   output logic link_led_n
);
   import optlink_pkg::*;

   generate
      if (QUAL_CYCLES < 1) begin : g_bad_qual
         $error("QUAL_CYCLES must be at least 1");
      end
      if (GAP_CYCLES < 2) begin : g_bad_gap
         $error("GAP_CYCLES must be at least 2");
      end
      if (SETTLE_MIN < 1) begin : g_bad_settle
         $error("SETTLE_MIN must be at least 1");
      end
      if (JIT_W < 1 || JIT_W > 15) begin : g_bad_jit
         $error("JIT_W must lie in 1..15");
      end
   endgenerate

   logic     amp_q_w;
   logic     trans_ok_w;
   logic     sig_good;
   logic     settle_start;
   logic     settle_run;
   logic     settle_done;
   link_st_e st, st_nx;

   optlink_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
      .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .trans_ok(trans_ok_w)
   );

   optlink_amp_qual #(.QUAL_CYCLES(QUAL_CYCLES)) u_amp (
      .clk(clk), .rst_n(rst_n), .amp_ok(amp_ok), .amp_q(amp_q_w)
   );

   optlink_settle #(
      .SETTLE_MIN(SETTLE_MIN), .JITTER_EN(JITTER_EN), .JIT_W(JIT_W), .SEED(SEED)
   ) u_settle (
      .clk(clk), .rst_n(rst_n), .start(settle_start), .run(settle_run), .done(settle_done)
   );

   assign sig_good   = amp_q_w && trans_ok_w;
   assign settle_run = (st == ST_SETTLE);

   always_comb begin
      st_nx        = st;
      settle_start = 1'b0;
      unique case (st)
         ST_DARK: begin
            if (sig_good) begin
               st_nx        = ST_SETTLE;
               settle_start = 1'b1;
            end
         end
         ST_SETTLE: begin
            if (!sig_good)       st_nx = ST_DARK;
            else if (settle_done) st_nx = ST_QUIET;
         end
         ST_QUIET: begin
            if (!sig_good)                st_nx = ST_DARK;
            else if (!tx_busy && !rx_busy) st_nx = ST_PASS;
         end
         ST_PASS: begin
            if (!sig_good) st_nx = ST_DARK;
         end
         default: st_nx = ST_DARK;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= ST_DARK;
      else        st <= st_nx;
   end

   assign tx_data_en = (st == ST_PASS);
   assign rx_en      = (st == ST_PASS);
   assign loop_en    = (st == ST_PASS);
   assign link_led_n = (st != ST_PASS);
endmodule

// File: rtl/optlink_mon_chk.sv
module optlink_mon_chk (
   input logic clk,
   input logic rst_n,
   input logic amp_ok,
   input logic tx_busy,
   input logic rx_busy,
   input logic amp_q,
   input logic trans_ok,
   input logic tx_data_en,
   input logic rx_en,
   input logic loop_en,
   input logic link_led_n
);
   // R5
   low_light_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(amp_q && trans_ok) |=> !tx_data_en);

   // R6
   enables_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_en == tx_data_en) && (loop_en == tx_data_en) && (link_led_n == !rx_en));

   // R9
   quiet_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_data_en) |-> $past(!tx_busy && !rx_busy));

   // R2
   qual_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(amp_q) |-> $past(amp_ok));

   // R3
   qual_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(amp_q) |-> !$past(amp_ok));
endmodule

bind optlink_mon optlink_mon_chk u_chk (
   .clk(clk), .rst_n(rst_n), .amp_ok(amp_ok), .tx_busy(tx_busy), .rx_busy(rx_busy),
   .amp_q(amp_q_w), .trans_ok(trans_ok_w), .tx_data_en(tx_data_en), .rx_en(rx_en),
   .loop_en(loop_en), .link_led_n(link_led_n)
);

// File: tb/optlink_mon_tb.sv
module optlink_mon_tb;
   localparam int CLK_PERIOD = 10;
   localparam int QC   = 4;
   localparam int GAP  = 8;
   localparam int SMIN = 20;
   localparam int JW   = 2;
   localparam int RISE = QC + SMIN + 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_bit = 1'b0;
   logic amp_ok = 1'b0;
   logic tx_busy = 1'b0;
   logic rx_busy = 1'b0;
   logic tx_data_en, rx_en, loop_en, link_led_n;
   logic j_tx, j_rx, j_lp, j_led;

   int  checks = 0;
   int  errors = 0;
   int  tog_period = 4;
   bit  tog_en = 1'b1;
   bit  done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   optlink_mon #(.QUAL_CYCLES(QC), .GAP_CYCLES(GAP), .SETTLE_MIN(SMIN), .JITTER_EN(1'b0), .JIT_W(JW)) u_dut (
      .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .amp_ok(amp_ok), .tx_busy(tx_busy), .rx_busy(rx_busy),
      .tx_data_en(tx_data_en), .rx_en(rx_en), .loop_en(loop_en), .link_led_n(link_led_n));

   optlink_mon #(.QUAL_CYCLES(QC), .GAP_CYCLES(GAP), .SETTLE_MIN(SMIN), .JITTER_EN(1'b1), .JIT_W(JW)) u_jit (
      .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .amp_ok(amp_ok), .tx_busy(tx_busy), .rx_busy(rx_busy),
      .tx_data_en(j_tx), .rx_en(j_rx), .loop_en(j_lp), .link_led_n(j_led));

   // transition source
   initial begin
      forever begin
         for (int k = 0; k < tog_period; k++) @(negedge clk);
         if (tog_en) rx_bit = ~rx_bit;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic bit up_all();
      return tx_data_en && rx_en && loop_en && !link_led_n;
   endfunction

   function automatic bit down_all();
      return !tx_data_en && !rx_en && !loop_en && link_led_n;
   endfunction

   task automatic wait_level(input bit want_up, input int limit, output int n);
      n = 0;
      while (n < limit) begin
         @(negedge clk);
         n++;
         if (want_up ? tx_data_en : !tx_data_en) break;
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(down_all(), "R1 outputs in reset", tx_data_en, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(down_all(), "R1 outputs after reset", tx_data_en, 0);
   endtask

   task automatic t_rise();
      int n, nj;
      bit jd;
      nj = 0; jd = 1'b0;
      amp_ok = 1'b1;
      n = 0;
      while (n < 60 && !(tx_data_en && jd)) begin
         @(negedge clk);
         n++;
         if (!jd && j_tx) begin jd = 1'b1; nj = n; end
         if (tx_data_en && n < RISE) break;
         if (n == RISE - 1) chk(down_all(), "R5 still low light before settle end", tx_data_en, 0);
         if (n == RISE) chk(up_all(), "R2 exact rise latency", n, RISE);
      end
      chk(up_all(), "R6 pass outputs", link_led_n, 0);
      chk(jd && nj >= RISE && nj <= RISE + (1 << JW) - 1, "R7 jittered rise window", nj, RISE);
      chk(j_tx && j_rx && j_lp && !j_led, "R6 jitter copy pass outputs", j_led, 0);
   endtask

   task automatic t_short_dropout();
      bit held;
      held = 1'b1;
      amp_ok = 1'b0;
      for (int k = 0; k < 2*QC - 1; k++) begin
         @(negedge clk);
         if (!up_all()) held = 1'b0;
      end
      amp_ok = 1'b1;
      repeat (12) begin
         @(negedge clk);
         if (!up_all()) held = 1'b0;
      end
      chk(held, "R3 short dropout ignored", held, 1);
   endtask

   task automatic t_gap_boundary();
      bit held;
      held = 1'b1;
      tog_period = GAP;
      repeat (80) begin
         @(negedge clk);
         if (!up_all()) held = 1'b0;
      end
      tog_period = 4;
      repeat (10) @(negedge clk);
      chk(held, "R4 gap equal to limit keeps link", held, 1);
   endtask

   task automatic t_busy_in_pass();
      bit held;
      held = 1'b1;
      tx_busy = 1'b1; rx_busy = 1'b1;
      repeat (20) begin
         @(negedge clk);
         if (!up_all()) held = 1'b0;
      end
      tx_busy = 1'b0; rx_busy = 1'b0;
      chk(held, "R10 activity ignored in pass", held, 1);
   endtask

   task automatic t_gap_loss();
      int n;
      @(rx_bit);
      tog_en = 1'b0;
      wait_level(1'b0, 40, n);
      chk(n == GAP + 2, "R4 gap loss latency", n, GAP + 2);
      chk(down_all(), "R5 low light after gap loss", link_led_n, 1);
      tog_en = 1'b1;
      wait_level(1'b1, 100, n);
      chk(up_all(), "R4 recovers after transitions return", tx_data_en, 1);
   endtask

   task automatic t_amp_loss();
      int n;
      amp_ok = 1'b0;
      wait_level(1'b0, 40, n);
      chk(n == 2*QC + 1, "R3 amplitude loss latency", n, 2*QC + 1);
      chk(down_all(), "R5 low light after amplitude loss", link_led_n, 1);
      repeat (5) @(negedge clk);
   endtask

   task automatic t_abort();
      int n;
      amp_ok = 1'b1;
      repeat (QC + 8) @(negedge clk);
      chk(down_all(), "R8 in settle, not yet pass", tx_data_en, 0);
      amp_ok = 1'b0;
      repeat (2*QC + 2) @(negedge clk);
      chk(down_all(), "R8 aborted to low light", tx_data_en, 0);
      amp_ok = 1'b1;
      wait_level(1'b1, 80, n);
      chk(n == RISE, "R8 settle restarts from zero", n, RISE);
      amp_ok = 1'b0;
      wait_level(1'b0, 40, n);
      repeat (5) @(negedge clk);
   endtask

   task automatic t_quiet(input bit use_tx);
      if (use_tx) tx_busy = 1'b1; else rx_busy = 1'b1;
      amp_ok = 1'b1;
      repeat (RISE + 6) @(negedge clk);
      chk(down_all(), use_tx ? "R9 waits for tx quiet" : "R9 waits for rx quiet", tx_data_en, 0);
      tx_busy = 1'b0; rx_busy = 1'b0;
      @(negedge clk);
      chk(up_all(), "R9 pass one edge after quiet", tx_data_en, 1);
      amp_ok = 1'b0;
      repeat (2*QC + 6) @(negedge clk);
   endtask

   initial begin
      t_reset();
      t_rise();
      t_short_dropout();
      t_gap_boundary();
      t_busy_in_pass();
      t_gap_loss();
      t_amp_loss();
      t_abort();
      t_quiet(1'b1);
      t_quiet(1'b0);
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule